// File: doc/BRIEF.md
# Privilege-Gated Cycle Stamp Counter

This block keeps a 64-bit counter that advances once per clock while the core is running. Software can sample the counter in two ways. The first is a dedicated stamp-read request that carries the requester's privilege level. The second is a generic register port, where the counter sits at one fixed address and can be both read and written.

A restriction flag can limit the dedicated read to the most privileged level (level 0). When a less privileged requester is refused, the block raises a one-cycle fault and returns zero instead of data. Writes through the register port follow one of two rules, chosen by an input. The legacy rule loads the low half of the counter and clears the high half. The full rule loads all 64 bits.

Counting normally follows a core-clock-active input, so the counter stops while the core sleeps. In the constant-rate mode the counter advances on every cycle, whatever the power state. A build parameter states whether this mode exists, and a capability output reports it.

Top module: `cycle_stamp_unit`

## Requirements
- R1: A synchronous active-high reset clears the counter, the restriction flag and every response output to zero.
- R2: The counter adds one per counting cycle and wraps from all-ones to zero. Back-to-back dedicated reads therefore return values that never decrease, except at that wrap.
- R3: When constant-rate mode is off and `clk_active` is low, the counter holds its value.
- R4: When constant-rate mode is built in and `invariant_en` is high, the counter advances every cycle, even while `clk_active` is low.
- R5: A granted dedicated read asserts `rd_valid` one cycle after `rd_req`. At that point `rd_data` holds the counter value from the request cycle.
- R6: With the flag clear, a dedicated read is granted at every privilege level 0 to 3. With the flag set, only level 0 is granted. A refused read asserts `rd_fault` for one cycle, keeps `rd_valid` low, drives `rd_data` to zero and leaves the counter untouched.
- R7: A register read at address 0x10 asserts `reg_rvalid` one cycle later, with all 64 counter bits on `reg_rdata`.
- R8: When `wide_wr` is 0 (legacy rule), a register write at 0x10 loads `reg_wdata[31:0]` into the low half and clears bits 63:32.
- R9: When `wide_wr` is 1 (full rule), a register write at 0x10 loads all 64 bits of `reg_wdata`.
- R10: A write takes precedence over an increment in the same cycle. Counting resumes from the written value on the next cycle.
- R11: A register access at any address other than 0x10 changes nothing and asserts `reg_err` for one cycle.
- R12: `cap_invariant` is 1 exactly when constant-rate mode is built in.
- R13: A pulse on `lock_we` loads `lock_val` into the restriction flag. The new flag value governs requests from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_active | input | 1 | Core clock running; enables counting outside constant-rate mode |
| invariant_en | input | 1 | Selects constant-rate counting |
| wide_wr | input | 1 | Write rule: 0 legacy low-half, 1 full width |
| lock_we | input | 1 | Load strobe for the restriction flag |
| lock_val | input | 1 | New value of the restriction flag |
| rd_req | input | 1 | Dedicated stamp-read request |
| rd_priv | input | 2 | Privilege level of the requester, 0 most privileged |
| rd_valid | output | 1 | Dedicated read granted, data valid |
| rd_data | output | 64 | Dedicated read data |
| rd_fault | output | 1 | Dedicated read refused |
| reg_en | input | 1 | Register port access strobe |
| reg_wr | input | 1 | Register port access is a write |
| reg_addr | input | 8 | Register port address |
| reg_wdata | input | 64 | Register port write data |
| reg_rvalid | output | 1 | Register read data valid |
| reg_rdata | output | 64 | Register read data |
| reg_err | output | 1 | Access to an unknown address |
| cap_invariant | output | 1 | Constant-rate mode is available |

## Verification
Counting is exercised in three settings: with the core running, with the core paused, and in constant-rate mode with the core paused. Only in constant-rate mode does a paused core still see the count move. Each setting writes a known value first and then reads after a known number of idle cycles. An off-by-one in the write priority or in the read latency therefore shows up as an exact mismatch. Dedicated reads are swept over all four privilege levels with the flag clear and then set, which separates the grant decision from the fault path. Writes of one pattern under each write rule, to the stamp address and to other addresses, separate the legacy clear, the full load and the ignored access.

// File: rtl/stamp_pkg.sv
package stamp_pkg;

  typedef enum logic {
    WR_LOW_HALF = 1'b0,
    WR_ALL_BITS = 1'b1
  } wr_rule_e;

endpackage

// File: rtl/stamp_counter.sv
module stamp_counter #(
  parameter int CNT_W     = 64,
  parameter bit CONST_RATE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_active,
  input  logic             invariant_en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count
);

  logic tick;

  generate
    if (CONST_RATE) begin : g_const
      assign tick = clk_active | invariant_en;
    end else begin : g_gated
      logic unused_inv;
      assign unused_inv = invariant_en;
      assign tick = clk_active;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (tick) begin
      count <= count + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

endmodule

// File: rtl/stamp_gate.sv
module stamp_gate #(
  parameter int CNT_W  = 64,
  parameter int PRIV_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_we,
  input  logic              lock_val,
  input  logic              rd_req,
  input  logic [PRIV_W-1:0] rd_priv,
  input  logic [CNT_W-1:0]  count,
  output logic              restrict_q,
  output logic              rd_valid,
  output logic [CNT_W-1:0]  rd_data,
  output logic              rd_fault
);

  logic granted;

  assign granted = !restrict_q || (rd_priv == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      restrict_q <= 1'b0;
    end else if (lock_we) begin
      restrict_q <= lock_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_fault <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req && granted;
      rd_fault <= rd_req && !granted;
      rd_data  <= (rd_req && granted) ? count : '0;
    end
  end

endmodule

// File: rtl/stamp_regport.sv
module stamp_regport
  import stamp_pkg::*;
#(
  parameter int              CNT_W      = 64,
  parameter int              ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] STAMP_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  input  logic              wide_wr,
  input  logic [CNT_W-1:0]  count,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              reg_rvalid,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              reg_err
);

  localparam int HALF_W = CNT_W / 2;

  logic     hit;
  wr_rule_e rule;

  assign hit  = (reg_addr == STAMP_ADDR);
  assign rule = wr_rule_e'(wide_wr);
  assign load = reg_en && reg_wr && hit;

  always_comb begin
    if (rule == WR_ALL_BITS) begin
      load_val = reg_wdata;
    end else begin
      load_val = {{(CNT_W-HALF_W){1'b0}}, reg_wdata[HALF_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
      reg_err    <= 1'b0;
    end else begin
      reg_rvalid <= reg_en && !reg_wr && hit;
      reg_rdata  <= (reg_en && !reg_wr && hit) ? count : '0;
      reg_err    <= reg_en && !hit;
    end
  end

endmodule

// File: rtl/cycle_stamp_unit.sv
module cycle_stamp_unit #(
  parameter int                CNT_W      = 64,
  parameter int                ADDR_W     = 8,
  parameter int                PRIV_W     = 2,
  parameter logic [ADDR_W-1:0] STAMP_ADDR = 8'h10,
  parameter bit                CONST_RATE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_active,
  input  logic              invariant_en,
  input  logic              wide_wr,
  input  logic              lock_we,
  input  logic              lock_val,
  input  logic              rd_req,
  input  logic [PRIV_W-1:0] rd_priv,
  output logic              rd_valid,
  output logic [CNT_W-1:0]  rd_data,
  output logic              rd_fault,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic              reg_rvalid,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              reg_err,
  output logic              cap_invariant
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] load_val;
  logic             load;
  logic             restrict_q;

  assign cap_invariant = CONST_RATE;

  stamp_counter #(
    .CNT_W      (CNT_W),
    .CONST_RATE (CONST_RATE)
  ) u_counter (
    .clk          (clk),
    .rst          (rst),
    .clk_active   (clk_active),
    .invariant_en (invariant_en),
    .load         (load),
    .load_val     (load_val),
    .count        (count_q)
  );

  stamp_regport #(
    .CNT_W      (CNT_W),
    .ADDR_W     (ADDR_W),
    .STAMP_ADDR (STAMP_ADDR)
  ) u_regport (
    .clk        (clk),
    .rst        (rst),
    .reg_en     (reg_en),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .wide_wr    (wide_wr),
    .count      (count_q),
    .load       (load),
    .load_val   (load_val),
    .reg_rvalid (reg_rvalid),
    .reg_rdata  (reg_rdata),
    .reg_err    (reg_err)
  );

  stamp_gate #(
    .CNT_W  (CNT_W),
    .PRIV_W (PRIV_W)
  ) u_gate (
    .clk        (clk),
    .rst        (rst),
    .lock_we    (lock_we),
    .lock_val   (lock_val),
    .rd_req     (rd_req),
    .rd_priv    (rd_priv),
    .count      (count_q),
    .restrict_q (restrict_q),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .rd_fault   (rd_fault)
  );

endmodule

// File: rtl/stamp_checker.sv
module stamp_checker #(
  parameter int                CNT_W      = 64,
  parameter int                ADDR_W     = 8,
  parameter int                PRIV_W     = 2,
  parameter logic [ADDR_W-1:0] STAMP_ADDR = 8'h10,
  parameter bit                CONST_RATE = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_active,
  input logic              invariant_en,
  input logic              wide_wr,
  input logic              rd_req,
  input logic [PRIV_W-1:0] rd_priv,
  input logic              rd_valid,
  input logic [CNT_W-1:0]  rd_data,
  input logic              rd_fault,
  input logic              reg_en,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [CNT_W-1:0]  reg_wdata,
  input logic              reg_err,
  input logic [CNT_W-1:0]  count,
  input logic              restrict_q
);

  logic any_wr;
  logic counting;

  assign any_wr   = reg_en && reg_wr && (reg_addr == STAMP_ADDR);
  assign counting = clk_active || (CONST_RATE && invariant_en);

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (counting && !any_wr) |=> (count == $past(count) + {{(CNT_W-1){1'b0}}, 1'b1})); // R2

  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!counting && !any_wr) |=> $stable(count)); // R3

  AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rd_fault && rd_valid)); // R6

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_fault |-> (rd_data == '0)); // R6

  AST_DENY_LOW: assert property (@(posedge clk) disable iff (rst)
    (rd_req && restrict_q && (rd_priv != '0)) |=> rd_fault); // R6

  AST_LEGACY_HIGH: assert property (@(posedge clk) disable iff (rst)
    (any_wr && !wide_wr) |=> (count[CNT_W-1:CNT_W/2] == '0)); // R8

  AST_FULL_LOAD: assert property (@(posedge clk) disable iff (rst)
    (any_wr && wide_wr) |=> (count == $past(reg_wdata))); // R9

  AST_BAD_ADDR: assert property (@(posedge clk) disable iff (rst)
    (reg_en && (reg_addr != STAMP_ADDR)) |=> (reg_err && $stable(count) || counting)); // R11

endmodule

bind cycle_stamp_unit stamp_checker #(
  .CNT_W      (CNT_W),
  .ADDR_W     (ADDR_W),
  .PRIV_W     (PRIV_W),
  .STAMP_ADDR (STAMP_ADDR),
  .CONST_RATE (CONST_RATE)
) u_stamp_checker (
  .clk          (clk),
  .rst          (rst),
  .clk_active   (clk_active),
  .invariant_en (invariant_en),
  .wide_wr      (wide_wr),
  .rd_req       (rd_req),
  .rd_priv      (rd_priv),
  .rd_valid     (rd_valid),
  .rd_data      (rd_data),
  .rd_fault     (rd_fault),
  .reg_en       (reg_en),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .reg_err      (reg_err),
  .count        (count_q),
  .restrict_q   (restrict_q)
);

// File: tb/test_cycle_stamp_unit.sv
`timescale 1ns/1ps
module test_cycle_stamp_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        clk_active, invariant_en, wide_wr, lock_we, lock_val;
  logic        rd_req;
  logic [1:0]  rd_priv;
  logic        rd_valid, rd_fault;
  logic [63:0] rd_data;
  logic        reg_en, reg_wr;
  logic [7:0]  reg_addr;
  logic [63:0] reg_wdata;
  logic        reg_rvalid, reg_err, cap_invariant;
  logic [63:0] reg_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  cycle_stamp_unit i_cycle_stamp_unit (
    .clk (clk), .rst (rst), .clk_active (clk_active), .invariant_en (invariant_en),
    .wide_wr (wide_wr), .lock_we (lock_we), .lock_val (lock_val),
    .rd_req (rd_req), .rd_priv (rd_priv), .rd_valid (rd_valid), .rd_data (rd_data),
    .rd_fault (rd_fault), .reg_en (reg_en), .reg_wr (reg_wr), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rvalid (reg_rvalid), .reg_rdata (reg_rdata),
    .reg_err (reg_err), .cap_invariant (cap_invariant)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [63:0] d, input logic wide);
    reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d; wide_wr = wide;
    @(negedge clk);
    reg_en = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [63:0] d,
                          output logic v, output logic e);
    reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
    @(negedge clk);
    d = reg_rdata; v = reg_rvalid; e = reg_err;
    reg_en = 1'b0;
  endtask

  task automatic stamp_read(input logic [1:0] p, output logic [63:0] d,
                            output logic v, output logic f);
    rd_req = 1'b1; rd_priv = p;
    @(negedge clk);
    d = rd_data; v = rd_valid; f = rd_fault;
    rd_req = 1'b0;
  endtask

  task automatic set_lock(input logic val);
    lock_we = 1'b1; lock_val = val;
    @(negedge clk);
    lock_we = 1'b0;
  endtask

  task automatic t_reset;
    logic [63:0] d; logic v, f;
    check("R1 rd_valid", {63'd0, rd_valid}, 64'd0);
    check("R1 rd_fault", {63'd0, rd_fault}, 64'd0);
    check("R1 reg_err", {63'd0, reg_err}, 64'd0);
    stamp_read(2'd3, d, v, f);
    check("R1 count after reset", d, 64'd0);
    check("R1 flag clear grants level 3", {63'd0, v}, 64'd1);
    check("R12 capability", {63'd0, cap_invariant}, 64'd1);
  endtask

  task automatic t_write_rules;
    logic [63:0] d; logic v, e;
    reg_write(8'h10, 64'h0123_4567_89AB_CDEF, 1'b1);
    reg_read(8'h10, d, v, e);
    check("R9 full write", d, 64'h0123_4567_89AB_CDEF);
    check("R7 rvalid", {63'd0, v}, 64'd1);
    reg_write(8'h10, 64'hFFEE_DDCC_1234_5678, 1'b0);
    reg_read(8'h10, d, v, e);
    check("R8 legacy write", d, 64'h0000_0000_1234_5678);
  endtask

  task automatic t_counting;
    logic [63:0] d, d2; logic v, f;
    clk_active = 1'b1;
    reg_write(8'h10, 64'd100, 1'b1);
    stamp_read(2'd1, d, v, f);
    check("R10 write wins over increment", d, 64'd100);
    check("R5 rd_valid", {63'd0, v}, 64'd1);
    idle(3);
    stamp_read(2'd1, d, v, f);
    check("R2 count after idle", d, 64'd104);
    stamp_read(2'd2, d2, v, f);
    check("R2 back-to-back step", d2, 64'd105);
    clk_active = 1'b0;
    reg_write(8'h10, 64'd500, 1'b1);
    idle(4);
    stamp_read(2'd0, d, v, f);
    check("R3 paused core holds", d, 64'd500);
  endtask

  task automatic t_invariant;
    logic [63:0] d; logic v, f;
    invariant_en = 1'b1;
    reg_write(8'h10, 64'd1000, 1'b1);
    idle(2);
    stamp_read(2'd0, d, v, f);
    check("R4 constant rate while paused", d, 64'd1002);
    reg_write(8'h10, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    stamp_read(2'd0, d, v, f);
    check("R2 before wrap", d, 64'hFFFF_FFFF_FFFF_FFFF);
    stamp_read(2'd0, d, v, f);
    check("R2 wrap to zero", d, 64'd0);
    invariant_en = 1'b0;
  endtask

  task automatic t_privilege;
    logic [63:0] d; logic v, f;
    reg_write(8'h10, 64'h55, 1'b1);
    for (int p = 0; p < 4; p++) begin
      stamp_read(p[1:0], d, v, f);
      check("R6 flag clear value", d, 64'h55);
      check("R6 flag clear no fault", {63'd0, f}, 64'd0);
    end
    set_lock(1'b1);
    stamp_read(2'd2, d, v, f);
    check("R6 refused fault", {63'd0, f}, 64'd1);
    check("R6 refused valid", {63'd0, v}, 64'd0);
    check("R6 refused data", d, 64'd0);
    idle(1);
    check("R6 fault one cycle", {63'd0, rd_fault}, 64'd0);
    stamp_read(2'd0, d, v, f);
    check("R13 level 0 granted", {63'd0, v}, 64'd1);
    check("R6 counter untouched", d, 64'h55);
    stamp_read(2'd3, d, v, f);
    check("R13 level 3 refused", {63'd0, f}, 64'd1);
    set_lock(1'b0);
    stamp_read(2'd3, d, v, f);
    check("R13 flag cleared", {63'd0, v}, 64'd1);
  endtask

  task automatic t_bad_addr;
    logic [63:0] d; logic v, e;
    reg_write(8'h20, 64'hDEAD, 1'b1);
    check("R11 write err", {63'd0, reg_err}, 64'd1);
    reg_read(8'h11, d, v, e);
    check("R11 read err", {63'd0, e}, 64'd1);
    check("R11 no rvalid", {63'd0, v}, 64'd0);
    idle(1);
    check("R11 err one cycle", {63'd0, reg_err}, 64'd0);
    reg_read(8'h10, d, v, e);
    check("R11 counter unchanged", d, 64'h55);
  endtask

  initial begin
    rst = 1'b1; clk_active = 1'b0; invariant_en = 1'b0; wide_wr = 1'b0;
    lock_we = 1'b0; lock_val = 1'b0; rd_req = 1'b0; rd_priv = 2'd0;
    reg_en = 1'b0; reg_wr = 1'b0; reg_addr = 8'd0; reg_wdata = 64'd0;
    idle(4);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_write_rules();
    t_counting();
    t_invariant();
    t_privilege();
    t_bad_addr();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule